// File: doc/BRIEF.md
# Prioritized Dual-Output Interrupt Controller

This block gathers up to 128 level-sensitive interrupt sources, organised as banks of 32 lines. Each line can be disabled by a mask bit, can be forced active by a software-set bit, carries a 6-bit priority level, and is steered to one of two outputs: a normal request output (`irq_o`) and a fast request output (`fiq_o`). Software programs and inspects it through a plain word-addressed register port with a write strobe and a combinational read path.

For each output, an arbiter looks at the pending lines steered to it. A line is pending when it is active (raw input or software bit) and not masked. The arbiter takes the line with the numerically smallest priority that also passes a global threshold. When a winner exists and the output is idle, the line number and its priority are captured and the output rises. Both then stay frozen until software writes the acknowledge bit for that output in the control word. That write drops the output, and a fresh arbitration follows on the next cycle.

Word addresses: 0x00 IRQ winner, 0x01 FIQ winner, 0x02 IRQ winner priority, 0x03 FIQ winner priority, 0x04 control, 0x05 threshold. Bank b occupies 0x10+8*b with these offsets: +0 raw inputs, +1 mask, +2 mask clear, +3 mask set, +4 software set (reads the software bits), +5 software clear, +6 IRQ pending, +7 FIQ pending. The level word of line n is at 0x40+n. Unlisted addresses read zero, and so do the write-only ports.

Top module: `prio_intc`

## Requirements
- R1: After reset every mask bit is 1, every software bit is 0, every level word reads 0 (IRQ route, priority 0), the threshold reads 0xFF and both outputs are low.
- R2: Line n appears in the raw-input word of bank n/32 at bit n%32, following the input pin with no register stage.
- R3: Writing the mask word loads it. Each 1 written to mask clear zeroes that mask bit, and each 1 written to mask set sets it. Bits written as 0 leave the mask unchanged.
- R4: Each 1 written to software set forces that line's software bit to 1, and each 1 written to software clear zeroes it. Reading the software-set address returns the software bits.
- R5: The IRQ-pending word equals (raw OR software) AND NOT mask AND NOT route. The FIQ-pending word uses route instead of NOT route.
- R6: A level word holds the route in bit 0 (1 = FIQ, 0 = IRQ) and the priority in bits 7:2. Bit 1 and bits 31:8 read 0.
- R7: Among eligible pending lines, the captured winner has the smallest priority value; on a tie, the lowest line number wins. A winner register reads the line number in bits 6:0 with zeros above. A priority register reads the winner's priority in bits 5:0 with zeros above.
- R8: When the threshold is 0xFF, all pending lines are eligible. Otherwise a line is eligible only if its priority is strictly less than the threshold.
- R9: While an output is low, its winner register and its priority register both read 0xFFFFFF80.
- R10: While an output is high, its line number and priority stay unchanged, whatever happens to inputs, masks, software bits or priorities.
- R11: Writing control bit 0 drops `irq_o`, and writing bit 1 drops `fiq_o`, at the clock edge of the write. Each acknowledge leaves the other output untouched. An output that is still pending rises again one cycle later.
- R12: An output rises at the first clock edge after a register update makes an eligible line pending, and not at the edge of that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 32*NUM_BANKS | Level interrupt inputs, one per line |
| bus_addr | input | 8 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the controller with two banks (64 lines). At that size it can sweep every line as a lone pending source, walk a one-hot input across both banks, and program all level words. Priorities repeat every 16 lines and every fifth line routes to FIQ, so ties and split routing arise constantly. On top of this come pseudo-random multi-line patterns under several thresholds, including the exact threshold boundary, the frozen-winner behaviour and acknowledges issued to one output only.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int BUS_AW     = 8;
    localparam int BUS_DW     = 32;
    localparam int BANK_LINES = 32;
    localparam int PRIO_W     = 6;
    localparam int LINE_W     = 7;
    localparam int THR_W      = 8;

    // global register addresses
    localparam int ADR_IRQ_NUM  = 'h00;
    localparam int ADR_FIQ_NUM  = 'h01;
    localparam int ADR_IRQ_PRIO = 'h02;
    localparam int ADR_FIQ_PRIO = 'h03;
    localparam int ADR_CTRL     = 'h04;
    localparam int ADR_THR      = 'h05;

    // per-bank block
    localparam int BANK_BASE   = 'h10;
    localparam int BANK_STRIDE = 8;
    localparam int OFS_RAW  = 0;
    localparam int OFS_MASK = 1;
    localparam int OFS_MCLR = 2;
    localparam int OFS_MSET = 3;
    localparam int OFS_SSET = 4;
    localparam int OFS_SCLR = 5;
    localparam int OFS_PIRQ = 6;
    localparam int OFS_PFIQ = 7;

    // per-line level words
    localparam int LVL_BASE     = 'h40;
    localparam int LVL_PRIO_LSB = 2;

    localparam logic [THR_W-1:0]  THR_OFF       = 8'hFF;
    localparam logic [BUS_DW-1:0] SPURIOUS_WORD = 32'hFFFF_FF80;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_HELD = 1'b1
    } out_state_e;

    typedef struct packed {
        out_state_e          st;
        logic [LINE_W-1:0]   line;
        logic [PRIO_W-1:0]   lvl;
    } arb_state_t;

endpackage

// File: rtl/prio_intc_cfg.sv
module prio_intc_cfg
    import prio_intc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int N = NUM_BANKS * BANK_LINES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [BUS_AW-1:0]       addr,
    input  logic [BUS_DW-1:0]       wdata,
    input  logic [N-1:0]            raw,
    output logic [N-1:0]            mask,
    output logic [N-1:0]            swi,
    output logic [N-1:0]            route,
    output logic [N-1:0][PRIO_W-1:0] prio,
    output logic [THR_W-1:0]        thr,
    output logic [N-1:0]            irq_pend,
    output logic [N-1:0]            fiq_pend
);

    typedef struct packed {
        logic [N-1:0]             mask;
        logic [N-1:0]             swi;
        logic [N-1:0]             route;
        logic [N-1:0][PRIO_W-1:0] prio;
        logic [THR_W-1:0]         thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [N-1:0] live;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (int'(addr) == ADR_THR) begin
                cfg_d.thr = wdata[THR_W-1:0];
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (int'(addr) == BANK_BASE + b * BANK_STRIDE + OFS_MASK) begin
                    cfg_d.mask[b*BANK_LINES +: BANK_LINES] = wdata;
                end
                if (int'(addr) == BANK_BASE + b * BANK_STRIDE + OFS_MCLR) begin
                    cfg_d.mask[b*BANK_LINES +: BANK_LINES] =
                        cfg_q.mask[b*BANK_LINES +: BANK_LINES] & ~wdata;
                end
                if (int'(addr) == BANK_BASE + b * BANK_STRIDE + OFS_MSET) begin
                    cfg_d.mask[b*BANK_LINES +: BANK_LINES] =
                        cfg_q.mask[b*BANK_LINES +: BANK_LINES] | wdata;
                end
                if (int'(addr) == BANK_BASE + b * BANK_STRIDE + OFS_SSET) begin
                    cfg_d.swi[b*BANK_LINES +: BANK_LINES] =
                        cfg_q.swi[b*BANK_LINES +: BANK_LINES] | wdata;
                end
                if (int'(addr) == BANK_BASE + b * BANK_STRIDE + OFS_SCLR) begin
                    cfg_d.swi[b*BANK_LINES +: BANK_LINES] =
                        cfg_q.swi[b*BANK_LINES +: BANK_LINES] & ~wdata;
                end
            end
            for (int i = 0; i < N; i++) begin
                if (int'(addr) == LVL_BASE + i) begin
                    cfg_d.route[i] = wdata[0];
                    cfg_d.prio[i]  = wdata[LVL_PRIO_LSB +: PRIO_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mask  <= '1;
            cfg_q.swi   <= '0;
            cfg_q.route <= '0;
            cfg_q.prio  <= '0;
            cfg_q.thr   <= THR_OFF;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign live     = (raw | cfg_q.swi) & ~cfg_q.mask;
    assign irq_pend = live & ~cfg_q.route;
    assign fiq_pend = live &  cfg_q.route;

    assign mask  = cfg_q.mask;
    assign swi   = cfg_q.swi;
    assign route = cfg_q.route;
    assign prio  = cfg_q.prio;
    assign thr   = cfg_q.thr;

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
    import prio_intc_pkg::*;
#(
    parameter int N = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             req,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    input  logic [THR_W-1:0]         thr,
    input  logic                     ack,
    output logic                     active,
    output logic [LINE_W-1:0]        line,
    output logic [PRIO_W-1:0]        lvl
);

    arb_state_t          st_d, st_q;
    logic                found;
    logic [LINE_W-1:0]   best_line;
    logic [PRIO_W-1:0]   best_prio;

    // lowest priority value wins, ascending scan keeps the lowest index on ties
    always_comb begin
        found     = 1'b0;
        best_line = '0;
        best_prio = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (thr == THR_OFF || THR_W'(prio[i]) < thr)) begin
                if (!found || prio[i] < best_prio) begin
                    found     = 1'b1;
                    best_line = LINE_W'(i);
                    best_prio = prio[i];
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.st == OUT_HELD) begin
            if (ack) begin
                st_d.st = OUT_IDLE;
            end
        end else if (found) begin
            st_d.st   = OUT_HELD;
            st_d.line = best_line;
            st_d.lvl  = best_prio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st   <= OUT_IDLE;
            st_q.line <= '0;
            st_q.lvl  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = (st_q.st == OUT_HELD);
    assign line   = st_q.line;
    assign lvl    = st_q.lvl;

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int N = NUM_BANKS * BANK_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_src,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [N-1:0]              mask_vec;
    logic [N-1:0]              swi_vec;
    logic [N-1:0]              route_vec;
    logic [N-1:0][PRIO_W-1:0]  prio_vec;
    logic [THR_W-1:0]          thr;
    logic [N-1:0]              irq_pend;
    logic [N-1:0]              fiq_pend;

    logic [1:0]                out_act;
    logic [1:0][LINE_W-1:0]    out_line;
    logic [1:0][PRIO_W-1:0]    out_lvl;
    logic [1:0]                ack_vec;

    prio_intc_cfg #(.NUM_BANKS(NUM_BANKS)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .raw      (irq_src),
        .mask     (mask_vec),
        .swi      (swi_vec),
        .route    (route_vec),
        .prio     (prio_vec),
        .thr      (thr),
        .irq_pend (irq_pend),
        .fiq_pend (fiq_pend)
    );

    // index 0 serves the IRQ output, index 1 the FIQ output
    for (genvar g = 0; g < 2; g++) begin : g_out
        logic [N-1:0] req_g;
        assign req_g      = (g == 0) ? irq_pend : fiq_pend;
        assign ack_vec[g] = bus_wr && (int'(bus_addr) == ADR_CTRL) && bus_wdata[g];

        prio_intc_arb #(.N(N)) arb_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_g),
            .prio   (prio_vec),
            .thr    (thr),
            .ack    (ack_vec[g]),
            .active (out_act[g]),
            .line   (out_line[g]),
            .lvl    (out_lvl[g])
        );
    end

    assign irq_o = out_act[0];
    assign fiq_o = out_act[1];

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < 2; g++) begin
            if (int'(bus_addr) == ADR_IRQ_NUM + g) begin
                bus_rdata = out_act[g] ? BUS_DW'(out_line[g]) : SPURIOUS_WORD;
            end
            if (int'(bus_addr) == ADR_IRQ_PRIO + g) begin
                bus_rdata = out_act[g] ? BUS_DW'(out_lvl[g]) : SPURIOUS_WORD;
            end
        end
        if (int'(bus_addr) == ADR_THR) begin
            bus_rdata = BUS_DW'(thr);
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bus_addr) == BANK_BASE + b * BANK_STRIDE + OFS_RAW)
                bus_rdata = irq_src[b*BANK_LINES +: BANK_LINES];
            if (int'(bus_addr) == BANK_BASE + b * BANK_STRIDE + OFS_MASK)
                bus_rdata = mask_vec[b*BANK_LINES +: BANK_LINES];
            if (int'(bus_addr) == BANK_BASE + b * BANK_STRIDE + OFS_SSET)
                bus_rdata = swi_vec[b*BANK_LINES +: BANK_LINES];
            if (int'(bus_addr) == BANK_BASE + b * BANK_STRIDE + OFS_PIRQ)
                bus_rdata = irq_pend[b*BANK_LINES +: BANK_LINES];
            if (int'(bus_addr) == BANK_BASE + b * BANK_STRIDE + OFS_PFIQ)
                bus_rdata = fiq_pend[b*BANK_LINES +: BANK_LINES];
        end
        for (int i = 0; i < N; i++) begin
            if (int'(bus_addr) == LVL_BASE + i) begin
                bus_rdata = BUS_DW'({prio_vec[i], 1'b0, route_vec[i]});
            end
        end
    end

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [LINE_W-1:0] irq_line,
    input logic              irq_pend_any,
    input logic [31:0]       mask_b0
);

    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (int'(bus_addr) == ADR_CTRL);

    // R11
    irq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[0] && irq_o) |=> !irq_o);

    // R11
    fiq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[1] && fiq_o) |=> !fiq_o);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(ctrl_wr && bus_wdata[0])) |=> (irq_o && $stable(irq_line)));

    // R12
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(irq_pend_any));

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) == BANK_BASE + OFS_MSET)
            |=> ((mask_b0 & $past(bus_wdata)) == $past(bus_wdata)));

endmodule

bind prio_intc prio_intc_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .irq_o        (irq_o),
    .fiq_o        (fiq_o),
    .irq_line     (out_line[0]),
    .irq_pend_any (|irq_pend),
    .mask_b0      (mask_vec[31:0])
);

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;

    localparam int NB = 2;
    localparam int NL = NB * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   irq_src = '0;
    logic [7:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_o, fiq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [NL-1:0] swi_m, mask_m;
    int            prio_m [NL];
    bit            route_m[NL];

    always #2 clk = ~clk;

    prio_intc #(.NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic int bank_adr(int b, int ofs);
        return 'h10 + 8 * b + ofs;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        #0.1;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = 8'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic rd_chk(int a, logic [31:0] exp, string req);
        logic [31:0] v;
        rd(a, v);
        chk(v === exp, req, 64'(v), 64'(exp));
    endtask

    // bench model of one output's arbitration
    task automatic expect_win(bit fiq, logic [7:0] thr, output bit found,
                              output int line, output int pr);
        found = 0; line = 0; pr = 0;
        for (int i = 0; i < NL; i++) begin
            if (swi_m[i] && !mask_m[i] && route_m[i] == fiq &&
                (thr == 8'hFF || prio_m[i] < int'(thr))) begin
                if (!found || prio_m[i] < pr) begin
                    found = 1; line = i; pr = prio_m[i];
                end
            end
        end
    endtask

    task automatic run_pattern(logic [NL-1:0] pat, logic [7:0] thr, string req);
        bit f0, f1;
        int l0, l1, p0, p1;
        wr('h05, 32'h0);
        wr('h04, 32'h3);
        for (int b = 0; b < NB; b++) wr(bank_adr(b, 5), 32'hFFFF_FFFF);
        for (int b = 0; b < NB; b++) wr(bank_adr(b, 4), pat[b*32 +: 32]);
        swi_m = pat;
        wr('h05, 32'(thr));
        // R12: not yet at the edge of the enabling write
        chk(irq_o == 0 && fiq_o == 0, "R12", 64'({irq_o, fiq_o}), 64'(0));
        expect_win(0, thr, f0, l0, p0);
        expect_win(1, thr, f1, l1, p1);
        @(negedge clk); #0.1;
        chk(irq_o == f0, {req, " R12 irq_o"}, 64'(irq_o), 64'(f0));
        chk(fiq_o == f1, {req, " R12 fiq_o"}, 64'(fiq_o), 64'(f1));
        rd_chk('h00, f0 ? 32'(l0) : 32'hFFFF_FF80, {req, " R7 R9 irq line"});
        rd_chk('h02, f0 ? 32'(p0) : 32'hFFFF_FF80, {req, " R7 R9 irq prio"});
        rd_chk('h01, f1 ? 32'(l1) : 32'hFFFF_FF80, {req, " R7 R9 fiq line"});
        rd_chk('h03, f1 ? 32'(p1) : 32'hFFFF_FF80, {req, " R7 R9 fiq prio"});
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [NL-1:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.1;

        // R1 reset state
        chk(irq_o == 0 && fiq_o == 0, "R1 outputs", 64'({irq_o, fiq_o}), 0);
        for (int b = 0; b < NB; b++) rd_chk(bank_adr(b, 1), 32'hFFFF_FFFF, "R1 mask");
        for (int b = 0; b < NB; b++) rd_chk(bank_adr(b, 4), 32'h0, "R1 swi");
        rd_chk('h05, 32'hFF, "R1 threshold");
        rd_chk('h40 + 5, 32'h0, "R1 level");
        rd_chk('h40 + NL - 1, 32'h0, "R1 level last");
        // R9 idle reads
        rd_chk('h00, 32'hFFFF_FF80, "R9 irq line idle");
        rd_chk('h03, 32'hFFFF_FF80, "R9 fiq prio idle");

        // R2 one-hot walk over the raw inputs
        for (int n = 0; n < NL; n++) begin
            irq_src = NL'(1) << n;
            for (int b = 0; b < NB; b++)
                rd_chk(bank_adr(b, 0), (b == n / 32) ? (32'h1 << (n % 32)) : 32'h0, "R2 raw");
        end
        irq_src = '0;

        // R3 mask ports
        wr(bank_adr(0, 2), 32'h0000_00F0);
        rd_chk(bank_adr(0, 1), 32'hFFFF_FF0F, "R3 clear");
        wr(bank_adr(0, 2), 32'h0);
        rd_chk(bank_adr(0, 1), 32'hFFFF_FF0F, "R3 zero clear");
        wr(bank_adr(0, 3), 32'h0000_0030);
        rd_chk(bank_adr(0, 1), 32'hFFFF_FF3F, "R3 set");
        wr(bank_adr(0, 3), 32'h0);
        rd_chk(bank_adr(0, 1), 32'hFFFF_FF3F, "R3 zero set");
        wr(bank_adr(1, 1), 32'h1234_5678);
        rd_chk(bank_adr(1, 1), 32'h1234_5678, "R3 load");
        rd_chk(bank_adr(1, 2), 32'h0, "R3 clear port reads zero");
        wr(bank_adr(0, 3), 32'hFFFF_FFFF);
        wr(bank_adr(1, 3), 32'hFFFF_FFFF);
        rd_chk(bank_adr(1, 1), 32'hFFFF_FFFF, "R3 set all");

        // R4 software bits (all lines masked, outputs stay low)
        wr(bank_adr(1, 4), 32'hA5);
        rd_chk(bank_adr(1, 4), 32'hA5, "R4 set");
        wr(bank_adr(1, 4), 32'h100);
        rd_chk(bank_adr(1, 4), 32'h1A5, "R4 set more");
        wr(bank_adr(1, 5), 32'h5);
        rd_chk(bank_adr(1, 4), 32'h1A0, "R4 clear");
        wr(bank_adr(1, 5), 32'hFFFF_FFFF);
        rd_chk(bank_adr(1, 4), 32'h0, "R4 clear all");

        // R6 level words: priorities repeat, every fifth line on FIQ
        for (int n = 0; n < NL; n++) begin
            prio_m[n]  = (n * 3) % 16;
            route_m[n] = (n % 5 == 0);
            wr('h40 + n, 32'(prio_m[n] << 2) | 32'(route_m[n]) | 32'hFFFF_FF02);
        end
        rd_chk('h40 + 7, 32'(prio_m[7] << 2), "R6 irq line");
        rd_chk('h40 + 45, 32'(prio_m[45] << 2) | 32'h1, "R6 fiq line");

        // R5 pending split, line 9 stays masked
        wr(bank_adr(0, 2), 32'h0000_00FF);
        irq_src = NL'(32'h0000_0205);
        wr(bank_adr(0, 4), 32'h0000_0008);
        rd_chk(bank_adr(0, 6), 32'h0000_000C, "R5 irq pending");
        rd_chk(bank_adr(0, 7), 32'h0000_0001, "R5 fiq pending");
        irq_src = '0;
        wr(bank_adr(0, 5), 32'hFFFF_FFFF);
        wr('h04, 32'h3);
        rd_chk(bank_adr(0, 6), 32'h0, "R5 irq pending cleared");

        // unmask all but line 39
        wr(bank_adr(0, 2), 32'hFFFF_FFFF);
        wr(bank_adr(1, 2), 32'hFFFF_FFFF);
        wr(bank_adr(1, 3), 32'h0000_0080);
        mask_m = '0;
        mask_m[39] = 1'b1;

        // R7 R12 single-line sweep
        for (int n = 0; n < NL; n++) run_pattern(NL'(1) << n, 8'hFF, "sweep");

        // R7 R8 multi-line patterns under several thresholds
        lfsr = 64'hACE1_1357_9BDF_2468;
        for (int k = 0; k < 25; k++) begin
            logic [7:0] t;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            case (k % 5)
                0: t = 8'hFF;
                1: t = 8'd8;
                2: t = 8'd1;
                3: t = 8'd16;
                default: t = 8'd3;
            endcase
            run_pattern(lfsr & (lfsr >> 7), t, "R8 pattern");
        end

        // R8 boundary: line 6 has priority 2
        run_pattern(NL'(1) << 6, 8'd2, "R8 equal blocked");
        run_pattern(NL'(1) << 6, 8'd3, "R8 below passes");

        // R10 frozen winner: line 6 (prio 2) then line 16 (prio 0)
        run_pattern(NL'(1) << 6, 8'hFF, "R10 setup");
        wr(bank_adr(0, 4), 32'h0001_0000);
        rd_chk('h00, 32'd6, "R10 held line");
        wr(bank_adr(0, 5), 32'h0000_0040);
        wr('h40 + 6, 32'h0);
        rd_chk('h00, 32'd6, "R10 held line after removal");
        rd_chk('h02, 32'd2, "R10 held prio");
        wr('h40 + 6, 32'(prio_m[6] << 2));
        // R11 ack drops at its edge, re-arbitrates one cycle later
        wr('h04, 32'h1);
        chk(irq_o == 0, "R11 irq drop", 64'(irq_o), 0);
        @(negedge clk); #0.1;
        chk(irq_o == 1, "R11 irq rearm", 64'(irq_o), 1);
        rd_chk('h00, 32'd16, "R11 new winner");

        // R11 independence: line 6 on IRQ, line 5 (prio 15) on FIQ
        run_pattern((NL'(1) << 6) | (NL'(1) << 5), 8'hFF, "R11 setup");
        wr('h04, 32'h2);
        chk(fiq_o == 0 && irq_o == 1, "R11 fiq only", 64'({irq_o, fiq_o}), 64'(2'b10));
        rd_chk('h00, 32'd6, "R11 irq untouched");
        chk(fiq_o == 1, "R11 fiq rearm", 64'(fiq_o), 1);
        rd_chk('h01, 32'd5, "R11 fiq winner");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule